// File: doc/BRIEF.md
# PLL Power-Up Sequencing Controller

This block owns the three mode control bits of an integer-mode PLL and steps them through a safe power-up and power-down order. On an enable request it first takes the PLL out of bypass. It then waits a timed settle interval and releases the PLL from reset. Next it waits for the loop to lock, and only then opens the output. Lock is judged in one of two ways, chosen by a parameter: a lock-status input with a timeout, or a fixed delay when no lock signal exists. A disable request shuts everything off in a single cycle.

The controller also holds the PLL's integer multiplier, the fractional numerator and denominator (set to 0 and 1 for integer mode), and the VCO band select bit. A retune request carries a new output rate. The controller sets the band bit, then writes the multiplier (rate divided by the reference rate). It restarts the PLL only if the PLL was running when the request arrived. All delays are counted in reference clock cycles, from a per-microsecond cycle count parameter.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset the mode word is 000, the multiplier is INIT_L, the numerator is 0, the denominator is 1, and busy, pll_on and lock_err are low.
- R2: Mode bit 1 is bypass-off, bit 2 is reset release and bit 0 is output enable. An enable sets bit 1 alone first, then bit 2, then bit 0, and never clears a bit on the way.
- R3: Reset release follows bypass-off after exactly SETTLE_US*CYC_PER_US cycles, whatever the lock input does meanwhile.
- R4: With a lock input, output enable is set on the first clock edge after reset release at which lock is high. If lock stays low for LOCK_TMO_US*CYC_PER_US cycles, output enable is set anyway and lock_err rises and stays high until reset.
- R5: Without a lock input, output enable is set exactly FIXED_LOCK_US*CYC_PER_US cycles after reset release.
- R6: A disable request accepted while idle clears all three mode bits on the next edge.
- R7: An enable request accepted while idle starts the sequence only if the mode word is 000. Otherwise the mode word does not change.
- R8: pll_on is high exactly when the mode word is 111.
- R9: busy is high from the edge that accepts a request until the sequence ends. Requests made while busy are ignored.
- R10: A retune sets vco_hi to (rate > LOW_BAND_MAX) and clears the mode word on the accepting edge. On the next edge it writes rate/REF_RATE into the multiplier. If the mode word was 111 it then runs the enable sequence; otherwise it stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | Enable request, sampled while idle |
| dis_req | input | 1 | Disable request; highest priority |
| tune_req | input | 1 | Retune request; priority above enable |
| tune_rate | input | RATE_W | Target output rate for a retune |
| pll_lock | input | 1 | PLL lock status (used when HAS_LOCK=1) |
| mode | output | 3 | {reset release, bypass-off, output enable} |
| mult_l | output | L_W | Integer multiplier |
| mult_m | output | L_W | Fractional numerator (0) |
| mult_n | output | L_W | Fractional denominator (1) |
| vco_hi | output | 1 | High VCO band select |
| pll_on | output | 1 | PLL fully enabled |
| busy | output | 1 | Sequence in progress |
| lock_err | output | 1 | Sticky lock timeout flag |

## Verification
A wrong state or counter shows first on the mode word. A bit set out of order, or a change one cycle early or late, is visible at the very edge where it happens. The bench therefore timestamps every mode change against a queue of expected transitions. A stuck sequencer shows within one wait interval as busy staying high and a missing transition. A wrong retune result shows on mult_l or vco_hi one edge after the request.

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl #(
  parameter int     CYC_PER_US    = 125,
  parameter int     SETTLE_US     = 10,
  parameter int     LOCK_TMO_US   = 100000,
  parameter int     FIXED_LOCK_US = 60,
  parameter bit     HAS_LOCK      = 1'b1,
  parameter int     RATE_W        = 32,
  parameter int     L_W           = 16,
  parameter longint REF_RATE      = 19200000,
  parameter longint LOW_BAND_MAX  = 1000000000,
  parameter int     INIT_L        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic              tune_req,
  input  logic [RATE_W-1:0] tune_rate,
  input  logic              pll_lock,
  output logic [2:0]        mode,
  output logic [L_W-1:0]    mult_l,
  output logic [L_W-1:0]    mult_m,
  output logic [L_W-1:0]    mult_n,
  output logic              vco_hi,
  output logic              pll_on,
  output logic              busy,
  output logic              lock_err
);
  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int WAIT_CYC   = HAS_LOCK ? LOCK_TMO_US * CYC_PER_US : FIXED_LOCK_US * CYC_PER_US;
  localparam int MAX_CYC    = (SETTLE_CYC > WAIT_CYC) ? SETTLE_CYC : WAIT_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1) + 1;
  localparam logic [RATE_W-1:0] REF_V = RATE_W'(REF_RATE);
  localparam logic [RATE_W-1:0] LOW_V = RATE_W'(LOW_BAND_MAX);
  localparam bit INIT_HI = (64'(INIT_L) * 64'(REF_RATE)) > 64'(LOW_BAND_MAX);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_LOCK, S_TUNE} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [RATE_W-1:0] rate_q;
  logic              was_on;

  wire lock_seen = HAS_LOCK ? pll_lock : 1'b0;

  assign busy   = (st != S_IDLE);
  assign pll_on = (mode == 3'b111);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      mode     <= 3'b000;
      mult_l   <= L_W'(INIT_L);
      mult_m   <= '0;
      mult_n   <= L_W'(1);
      vco_hi   <= INIT_HI;
      lock_err <= 1'b0;
      rate_q   <= '0;
      was_on   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (dis_req) begin
            mode <= 3'b000;
          end else if (tune_req) begin
            was_on <= (mode == 3'b111);
            mode   <= 3'b000;
            vco_hi <= (tune_rate > LOW_V);
            rate_q <= tune_rate;
            st     <= S_TUNE;
          end else if (en_req && mode == 3'b000) begin
            mode <= 3'b010;
            st   <= S_SETTLE;
          end
        end
        S_TUNE: begin
          mult_l <= L_W'(rate_q / REF_V);
          if (was_on) begin
            mode <= 3'b010;
            st   <= S_SETTLE;
          end else begin
            st <= S_IDLE;
          end
        end
        S_SETTLE: begin
          if (cnt == CW'(SETTLE_CYC - 1)) begin
            mode[2] <= 1'b1;
            cnt     <= '0;
            st      <= S_LOCK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LOCK: begin
          if (lock_seen) begin
            mode[0] <= 1'b1;
            st      <= S_IDLE;
          end else if (cnt == CW'(WAIT_CYC - 1)) begin
            mode[0] <= 1'b1;
            if (HAS_LOCK) lock_err <= 1'b1;
            st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (mode == 3'b010) gap <= gap + 1'b1;
    else gap <= '0;
  end

  p_settle_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[2]) |-> gap >= CW'(SETTLE_CYC));

  p_reset_after_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[2]) |-> mode[1] && $past(mode[1]));

  p_output_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[0]) |-> mode[2:1] == 2'b11);

  p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_req && !busy) |=> mode == 3'b000);

  p_enable_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && !dis_req && !tune_req && !busy && mode != 3'b000) |=> $stable(mode));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> lock_err);
endmodule

// File: tb/pll_seq_ctrl_tb.sv
module pll_seq_ctrl_tb;
  localparam int CPU = 2;
  localparam int S   = 10 * CPU;
  localparam int TO  = 50 * CPU;
  localparam int F   = 60 * CPU;

  logic clk = 0, rst_n = 0;
  logic en_req = 0, dis_req = 0, tune_req = 0, pll_lock = 0, en_b = 0;
  logic [31:0] tune_rate = '0;
  logic [2:0] mode, mode_b;
  logic [15:0] mult_l, mult_m, mult_n, l_b, m_b, n_b;
  logic vco_hi, pll_on, busy, lock_err, vco_b, on_b, busy_b, err_b;

  always #4 clk = ~clk;

  pll_seq_ctrl #(.CYC_PER_US(CPU), .LOCK_TMO_US(50)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .tune_req(tune_req),
    .tune_rate(tune_rate), .pll_lock(pll_lock), .mode(mode), .mult_l(mult_l),
    .mult_m(mult_m), .mult_n(mult_n), .vco_hi(vco_hi), .pll_on(pll_on), .busy(busy),
    .lock_err(lock_err));

  pll_seq_ctrl #(.CYC_PER_US(CPU), .HAS_LOCK(1'b0)) u_dut_fx (
    .clk(clk), .rst_n(rst_n), .en_req(en_b), .dis_req(1'b0), .tune_req(1'b0),
    .tune_rate(32'd0), .pll_lock(1'b0), .mode(mode_b), .mult_l(l_b),
    .mult_m(m_b), .mult_n(n_b), .vco_hi(vco_b), .pll_on(on_b), .busy(busy_b),
    .lock_err(err_b));

  int cyc = 0, n_chk = 0, n_err = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [2:0] m; int t; string r; } exp_t;
  exp_t exp_q[$];
  logic [2:0] prev_mode = 3'b000;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mode !== prev_mode) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected mode change", mode, prev_mode);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.r, " mode value"}, mode, e.m);
        chk({e.r, " mode change cycle"}, cyc, e.t);
      end
    end
    prev_mode = mode;
  end

  task automatic push(input logic [2:0] m, input int t, input string r);
    exp_t e;
    e.m = m; e.t = t; e.r = r;
    exp_q.push_back(e);
  endtask

  task automatic wait_to(input int t);
    while (cyc != t) @(negedge clk);
  endtask

  task automatic pulse(input int which, output int t0);
    @(negedge clk);
    t0 = cyc + 1;
    case (which)
      0: en_req = 1;
      1: dis_req = 1;
      2: tune_req = 1;
      default: en_b = 1;
    endcase
    @(negedge clk);
    en_req = 0; dis_req = 0; tune_req = 0; en_b = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);     chk("R1 mult_l", mult_l, 32);
    chk("R1 mult_m", mult_m, 0); chk("R1 mult_n", mult_n, 1);
    chk("R1 busy", busy, 0);     chk("R1 pll_on", pll_on, 0);
    chk("R1 lock_err", lock_err, 0); chk("R1 vco_hi", vco_hi, 0);

    // R2 R3 R4: enable with lock already high; R9 request while busy
    pll_lock = 1;
    @(negedge clk);
    t0 = cyc + 1;
    push(3'b010, t0, "R2"); push(3'b110, t0 + S, "R3"); push(3'b111, t0 + S + 1, "R4");
    en_req = 1; @(negedge clk); en_req = 0;
    chk("R9 busy during sequence", busy, 1);
    wait_to(t0 + 5);
    en_req = 1; dis_req = 1; @(negedge clk); en_req = 0; dis_req = 0;
    wait_to(t0 + S + 2);
    chk("R8 pll_on", pll_on, 1); chk("R9 busy after", busy, 0);

    // R7 enable while on ignored
    pulse(0, t0);
    repeat (4) @(negedge clk);
    chk("R7 mode stays on", mode, 7);

    // R6 disable
    @(negedge clk); push(3'b000, cyc + 1, "R6");
    dis_req = 1; @(negedge clk); dis_req = 0;
    chk("R8 pll_on off", pll_on, 0);

    // R10 retune while off
    tune_rate = 32'd1152000000;
    pulse(2, t0);
    chk("R10 vco set first", vco_hi, 1); chk("R10 L not yet", mult_l, 32);
    @(negedge clk);
    chk("R10 L written", mult_l, 60); chk("R10 stays off", mode, 0);
    chk("R10 idle", busy, 0);

    // R4 lock wait
    pll_lock = 0;
    @(negedge clk); t0 = cyc + 1;
    push(3'b010, t0, "R2"); push(3'b110, t0 + S, "R3"); push(3'b111, t0 + S + 6, "R4 lock");
    en_req = 1; @(negedge clk); en_req = 0;
    wait_to(t0 + S + 5);
    pll_lock = 1;
    wait_to(t0 + S + 8);
    chk("R4 no error on lock", lock_err, 0);

    // R10 retune while on
    tune_rate = 32'd768000000;
    @(negedge clk); t0 = cyc + 1;
    push(3'b000, t0, "R10 off"); push(3'b010, t0 + 1, "R10 restart");
    push(3'b110, t0 + 1 + S, "R10 R3"); push(3'b111, t0 + S + 2, "R10 R4");
    tune_req = 1; @(negedge clk); tune_req = 0;
    chk("R10 vco cleared", vco_hi, 0); chk("R10 L old", mult_l, 60);
    @(negedge clk);
    chk("R10 L new", mult_l, 40);
    wait_to(t0 + S + 4);
    chk("R10 back on", pll_on, 1);

    // R4 timeout
    @(negedge clk); push(3'b000, cyc + 1, "R6");
    dis_req = 1; @(negedge clk); dis_req = 0;
    pll_lock = 0;
    @(negedge clk); t0 = cyc + 1;
    push(3'b010, t0, "R2"); push(3'b110, t0 + S, "R3"); push(3'b111, t0 + S + TO, "R4 timeout");
    en_req = 1; @(negedge clk); en_req = 0;
    wait_to(t0 + S + TO - 1);
    chk("R4 no err before timeout", lock_err, 0);
    @(negedge clk);
    chk("R4 timeout err", lock_err, 1);
    @(negedge clk); push(3'b000, cyc + 1, "R6");
    dis_req = 1; @(negedge clk); dis_req = 0;
    pll_lock = 1;
    @(negedge clk); t0 = cyc + 1;
    push(3'b010, t0, "R2"); push(3'b110, t0 + S, "R3"); push(3'b111, t0 + S + 1, "R4");
    en_req = 1; @(negedge clk); en_req = 0;
    wait_to(t0 + S + 3);
    chk("R4 err sticky", lock_err, 1);

    // R5 fixed delay instance
    pulse(3, t0);
    wait_to(t0 + S + F - 1);
    chk("R5 before fixed delay", mode_b, 6);
    @(negedge clk);
    chk("R5 after fixed delay", mode_b, 7);
    chk("R5 pll_on", on_b, 1);

    repeat (3) @(negedge clk);
    chk("R2 all expected transitions seen", exp_q.size(), 0);
    finish_run();
  end
endmodule